// File: doc/BRIEF.md
# Touch Prefetch Filter and Buffer

This block takes software prefetch hints, which come in two kinds: touch-for-load and touch-for-store. Each hint arrives with a block address and the result of translating it. The translation result says whether the lookup hit and whether loads are allowed, and gives the page attributes guarded, write-through and caching-inhibited. The block also sees whether the cache is locked or disabled. A hint that passes every condition starts a fetch from memory and pulses an LRU-update strobe. A hint that fails any condition is dropped as a no-op.

The fetched block is kept in a single-entry touch buffer until it is moved into the cache. Several events empty the buffer: the move into the cache, any data cache management command, a zero-block command that hits the buffered block address, and any newer hint. A newer hint that qualifies takes over the buffer for its own fetch.

Fetches go out on a simple request/response port. Every request carries a small id. A response is taken only if its id matches the latest request and that request has not been cancelled. Because of this, data for a cancelled fetch is always discarded. The block never requests an update of the page-table reference or change bits.

Top module: `touch_prefetch_buf`

## Requirements
- R1: A hint with translation hit, load permission, cache neither locked nor disabled, and a page that is not guarded, not write-through and not caching-inhibited gives a one-cycle `fetch_req_o` and `lru_upd_o` in the next cycle. In that cycle `fetch_addr_o` and `lru_addr_o` carry the hint address, and `fetch_id_o` is the previous id plus one, modulo 2^ID_W, starting from 0 after reset.
- R2: A hint that fails any condition of R1 gives a one-cycle `hint_nop_o` in the next cycle, with no `fetch_req_o` and no `lru_upd_o`.
- R3: `hint_store_i`=1 selects touch-for-store. Its filter rules are the same, but `fetch_rwitm_o` is 1 with the request and `buf_rwitm_o` is 1 once the block is buffered. `hint_store_i`=0 gives 0 in both places.
- R4: `pte_rc_upd_o` is never asserted.
- R5: A response with `rsp_valid_i`=1 and `rsp_id_i` equal to the current `fetch_id_o`, arriving while that fetch is outstanding and in a cycle with no invalidating event, sets `buf_valid_o` in the next cycle. The buffer then holds `rsp_data_i`, the hinted address and the intent flag.
- R6: `move_i` while the buffer is valid makes `buf_valid_o` 0 in the next cycle. `move_i` at any other time has no effect.
- R7: `cmo_i` empties the buffer in the next cycle and cancels any outstanding fetch, so its response is discarded.
- R8: A zero-block command (`zero_valid_i`) whose `zero_addr_i` equals the address of the valid or outstanding block empties the buffer and cancels the fetch. A zero-block command to any other address has no effect.
- R9: Any hint, qualified or not, empties the buffer and cancels an outstanding fetch. A qualified hint then starts its own fetch.
- R10: A response whose id does not match, or one that arrives while no fetch is outstanding, is ignored.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hint_valid_i | input | 1 | Hint command this cycle |
| hint_store_i | input | 1 | 1 = touch-for-store, 0 = touch-for-load |
| hint_addr_i | input | ADDR_W | Block address of the hint |
| xlat_hit_i | input | 1 | Translation hit |
| xlat_load_ok_i | input | 1 | Page grants load access |
| page_guarded_i | input | 1 | Page is guarded |
| page_wt_i | input | 1 | Page is write-through |
| page_ci_i | input | 1 | Page is caching-inhibited |
| cache_locked_i | input | 1 | Data cache locked |
| cache_disabled_i | input | 1 | Data cache disabled |
| cmo_i | input | 1 | Any data cache management command |
| zero_valid_i | input | 1 | Zero-block command |
| zero_addr_i | input | ADDR_W | Block address of the zero-block command |
| move_i | input | 1 | Buffer contents moved into the cache |
| rsp_valid_i | input | 1 | Memory response valid |
| rsp_id_i | input | ID_W | Id of the response |
| rsp_data_i | input | BLK_BYTES*8 | Response block data |
| fetch_req_o | output | 1 | Fetch request pulse |
| fetch_addr_o | output | ADDR_W | Fetch block address |
| fetch_rwitm_o | output | 1 | Fetch with intent to modify |
| fetch_id_o | output | ID_W | Id of the latest request |
| lru_upd_o | output | 1 | LRU-update strobe |
| lru_addr_o | output | ADDR_W | Block touched for LRU |
| hint_nop_o | output | 1 | Hint dropped as a no-op |
| pte_rc_upd_o | output | 1 | Page-table R/C update request (always 0) |
| buf_valid_o | output | 1 | Touch buffer holds a block |
| buf_addr_o | output | ADDR_W | Buffered block address |
| buf_rwitm_o | output | 1 | Buffered block fetched with intent to modify |
| buf_data_o | output | BLK_BYTES*8 | Buffered block data |

## Verification
Suppose the filter decodes a condition wrongly. The error shows one cycle after the hint, as a `fetch_req_o` or `hint_nop_o` pulse where the other was due. Suppose instead the outstanding flag or the buffer state holds a wrong value. The error can stay hidden until the next response or invalidating event, and then shows one cycle later. It appears as `buf_valid_o` rising for a cancelled or stale fetch, or staying high after a move, a management command, a matching zero-block command or a new hint. Random stimulus uses only a handful of addresses, so that zero-block matches happen, and most responses carry the current id, so that acceptance and cancellation race often.

// File: rtl/touch_pkg.sv
package touch_pkg;
  typedef enum logic [1:0] {
    BUF_EMPTY = 2'd0,
    BUF_PEND  = 2'd1,
    BUF_FULL  = 2'd2
  } buf_state_e;
endpackage

// File: rtl/touch_filter.sv
module touch_filter (
  input  logic xlat_hit_i,
  input  logic xlat_load_ok_i,
  input  logic page_guarded_i,
  input  logic page_wt_i,
  input  logic page_ci_i,
  input  logic cache_locked_i,
  input  logic cache_disabled_i,
  output logic qual_o
);
  logic xlat_ok, page_ok, cache_ok;

  always_comb begin
    xlat_ok  = xlat_hit_i & xlat_load_ok_i;
    page_ok  = ~(page_guarded_i | page_wt_i | page_ci_i);
    cache_ok = ~(cache_locked_i | cache_disabled_i);
    qual_o   = xlat_ok & page_ok & cache_ok;
  end
endmodule

// File: rtl/touch_issue.sv
module touch_issue #(
  parameter int ADDR_W = 27,
  parameter int ID_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hint_valid_i,
  input  logic              hint_store_i,
  input  logic [ADDR_W-1:0] hint_addr_i,
  input  logic              qual_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              fetch_rwitm_o,
  output logic [ID_W-1:0]   fetch_id_o,
  output logic              lru_upd_o,
  output logic [ADDR_W-1:0] lru_addr_o,
  output logic              hint_nop_o
);
  logic              req_q, nop_q, rwitm_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ID_W-1:0]   id_q;
  logic              issue;

  assign issue = hint_valid_i & qual_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      nop_q   <= 1'b0;
      rwitm_q <= 1'b0;
      addr_q  <= '0;
      id_q    <= '0;
    end else begin
      req_q <= issue;
      nop_q <= hint_valid_i & ~qual_i;
      if (issue) begin
        addr_q  <= hint_addr_i;
        rwitm_q <= hint_store_i;
        id_q    <= id_q + 1'b1;
      end
    end
  end

  assign fetch_req_o   = req_q;
  assign fetch_addr_o  = addr_q;
  assign fetch_rwitm_o = rwitm_q;
  assign fetch_id_o    = id_q;
  assign lru_upd_o     = req_q;
  assign lru_addr_o    = addr_q;
  assign hint_nop_o    = nop_q;

  // R1
  req_from_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> $past(hint_valid_i && qual_i));
  // R2
  nop_or_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_req_o && hint_nop_o));
  // R2
  hint_answered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_valid_i |=> (fetch_req_o || hint_nop_o));
endmodule

// File: rtl/touch_buf.sv
module touch_buf
  import touch_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int ID_W   = 2,
  parameter int DATA_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hint_valid_i,
  input  logic              hint_store_i,
  input  logic [ADDR_W-1:0] hint_addr_i,
  input  logic              qual_i,
  input  logic              cmo_i,
  input  logic              zero_valid_i,
  input  logic [ADDR_W-1:0] zero_addr_i,
  input  logic              move_i,
  input  logic              rsp_valid_i,
  input  logic [ID_W-1:0]   rsp_id_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic [ID_W-1:0]   cur_id_i,
  output logic              buf_valid_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic              buf_rwitm_o,
  output logic [DATA_W-1:0] buf_data_o
);
  buf_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rwitm_q;
  logic [DATA_W-1:0] data_q;
  logic              held, zero_hit, kill, accept;

  always_comb begin
    held     = (st_q != BUF_EMPTY);
    zero_hit = zero_valid_i & held & (zero_addr_i == addr_q);
    kill     = hint_valid_i | cmo_i | zero_hit;
    accept   = rsp_valid_i & (st_q == BUF_PEND) & (rsp_id_i == cur_id_i) & ~kill;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BUF_EMPTY;
      addr_q  <= '0;
      rwitm_q <= 1'b0;
      data_q  <= '0;
    end else if (hint_valid_i) begin
      st_q <= qual_i ? BUF_PEND : BUF_EMPTY;
      if (qual_i) begin
        addr_q  <= hint_addr_i;
        rwitm_q <= hint_store_i;
      end
    end else if (kill) begin
      st_q <= BUF_EMPTY;
    end else if (accept) begin
      st_q   <= BUF_FULL;
      data_q <= rsp_data_i;
    end else if (move_i && st_q == BUF_FULL) begin
      st_q <= BUF_EMPTY;
    end
  end

  assign buf_valid_o = (st_q == BUF_FULL);
  assign buf_addr_o  = addr_q;
  assign buf_rwitm_o = rwitm_q;
  assign buf_data_o  = data_q;

  // R5
  fill_needs_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_valid_o) |-> $past(rsp_valid_i && rsp_id_i == cur_id_i));
  // R6
  move_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (move_i && buf_valid_o) |=> !buf_valid_o);
  // R7
  cmo_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmo_i |=> !buf_valid_o);
  // R8
  zero_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_valid_i && buf_valid_o && zero_addr_i == buf_addr_o) |=> !buf_valid_o);
  // R9
  hint_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_valid_i |=> !buf_valid_o);
endmodule

// File: rtl/touch_prefetch_buf.sv
module touch_prefetch_buf #(
  parameter int ADDR_W    = 27,
  parameter int BLK_BYTES = 32,
  parameter int ID_W      = 2,
  localparam int DATA_W   = BLK_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hint_valid_i,
  input  logic              hint_store_i,
  input  logic [ADDR_W-1:0] hint_addr_i,
  input  logic              xlat_hit_i,
  input  logic              xlat_load_ok_i,
  input  logic              page_guarded_i,
  input  logic              page_wt_i,
  input  logic              page_ci_i,
  input  logic              cache_locked_i,
  input  logic              cache_disabled_i,
  input  logic              cmo_i,
  input  logic              zero_valid_i,
  input  logic [ADDR_W-1:0] zero_addr_i,
  input  logic              move_i,
  input  logic              rsp_valid_i,
  input  logic [ID_W-1:0]   rsp_id_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              fetch_rwitm_o,
  output logic [ID_W-1:0]   fetch_id_o,
  output logic              lru_upd_o,
  output logic [ADDR_W-1:0] lru_addr_o,
  output logic              hint_nop_o,
  output logic              pte_rc_upd_o,
  output logic              buf_valid_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic              buf_rwitm_o,
  output logic [DATA_W-1:0] buf_data_o
);
  logic qual;

  touch_filter u_filter (
    .xlat_hit_i      (xlat_hit_i),
    .xlat_load_ok_i  (xlat_load_ok_i),
    .page_guarded_i  (page_guarded_i),
    .page_wt_i       (page_wt_i),
    .page_ci_i       (page_ci_i),
    .cache_locked_i  (cache_locked_i),
    .cache_disabled_i(cache_disabled_i),
    .qual_o          (qual)
  );

  touch_issue #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_issue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hint_valid_i (hint_valid_i),
    .hint_store_i (hint_store_i),
    .hint_addr_i  (hint_addr_i),
    .qual_i       (qual),
    .fetch_req_o  (fetch_req_o),
    .fetch_addr_o (fetch_addr_o),
    .fetch_rwitm_o(fetch_rwitm_o),
    .fetch_id_o   (fetch_id_o),
    .lru_upd_o    (lru_upd_o),
    .lru_addr_o   (lru_addr_o),
    .hint_nop_o   (hint_nop_o)
  );

  touch_buf #(.ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hint_valid_i(hint_valid_i),
    .hint_store_i(hint_store_i),
    .hint_addr_i (hint_addr_i),
    .qual_i      (qual),
    .cmo_i       (cmo_i),
    .zero_valid_i(zero_valid_i),
    .zero_addr_i (zero_addr_i),
    .move_i      (move_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_id_i    (rsp_id_i),
    .rsp_data_i  (rsp_data_i),
    .cur_id_i    (fetch_id_o),
    .buf_valid_o (buf_valid_o),
    .buf_addr_o  (buf_addr_o),
    .buf_rwitm_o (buf_rwitm_o),
    .buf_data_o  (buf_data_o)
  );

  // prefetch hints never touch page-table R/C bits
  assign pte_rc_upd_o = 1'b0;
endmodule

// File: tb/touch_prefetch_buf_tb.sv
module touch_prefetch_buf_tb;
  localparam int AW = 27;
  localparam int IW = 2;
  localparam int DW = 256;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic hint_valid_i, hint_store_i, xlat_hit_i, xlat_load_ok_i;
  logic page_guarded_i, page_wt_i, page_ci_i, cache_locked_i, cache_disabled_i;
  logic cmo_i, zero_valid_i, move_i, rsp_valid_i;
  logic [AW-1:0] hint_addr_i, zero_addr_i;
  logic [IW-1:0] rsp_id_i;
  logic [DW-1:0] rsp_data_i;
  logic fetch_req_o, fetch_rwitm_o, lru_upd_o, hint_nop_o, pte_rc_upd_o;
  logic buf_valid_o, buf_rwitm_o;
  logic [AW-1:0] fetch_addr_o, lru_addr_o, buf_addr_o;
  logic [IW-1:0] fetch_id_o;
  logic [DW-1:0] buf_data_o;

  always #2 clk_i = ~clk_i;

  touch_prefetch_buf u_dut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  bit m_pend, m_vld, m_rw, e_req, e_nop, e_rw;
  logic [AW-1:0] m_addr, e_addr;
  logic [IW-1:0] m_id;
  logic [DW-1:0] m_data;
  string cause;

  function automatic bit f_qual();
    return xlat_hit_i && xlat_load_ok_i && !page_guarded_i && !page_wt_i &&
           !page_ci_i && !cache_locked_i && !cache_disabled_i;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    hint_valid_i = 0; hint_store_i = 0; hint_addr_i = '0;
    xlat_hit_i = 1; xlat_load_ok_i = 1; page_guarded_i = 0; page_wt_i = 0;
    page_ci_i = 0; cache_locked_i = 0; cache_disabled_i = 0;
    cmo_i = 0; zero_valid_i = 0; zero_addr_i = '0; move_i = 0;
    rsp_valid_i = 0; rsp_id_i = '0; rsp_data_i = '0;
  endtask

  task automatic step();
    bit q, kill, acc;
    @(posedge clk_i);
    q    = hint_valid_i && f_qual();
    kill = hint_valid_i || cmo_i ||
           (zero_valid_i && (m_pend || m_vld) && zero_addr_i == m_addr);
    acc  = rsp_valid_i && m_pend && rsp_id_i == m_id && !kill;
    e_req = q;
    e_nop = hint_valid_i && !q;
    if (q) begin e_addr = hint_addr_i; e_rw = hint_store_i; m_id = m_id + 1'b1; end
    cause = "R10";
    if (hint_valid_i) begin
      m_vld = 0; m_pend = q; cause = "R9";
      if (q) begin m_addr = hint_addr_i; m_rw = hint_store_i; end
    end else if (kill) begin
      m_vld = 0; m_pend = 0; cause = cmo_i ? "R7" : "R8";
    end else if (acc) begin
      m_vld = 1; m_pend = 0; m_data = rsp_data_i; cause = "R5";
    end else if (move_i && m_vld) begin
      m_vld = 0; cause = "R6";
    end else if (zero_valid_i) cause = "R8";
    #1;
    chk(fetch_req_o == e_req && lru_upd_o == e_req, "R1 req/lru", fetch_req_o, e_req);
    if (e_req) begin
      chk(fetch_addr_o == e_addr && lru_addr_o == e_addr && fetch_id_o == m_id,
          "R1 addr/id", {fetch_id_o, fetch_addr_o}, {m_id, e_addr});
      chk(fetch_rwitm_o == e_rw, "R3 fetch intent", fetch_rwitm_o, e_rw);
    end
    chk(hint_nop_o == e_nop, "R2 nop", hint_nop_o, e_nop);
    chk(pte_rc_upd_o == 1'b0, "R4 rc", pte_rc_upd_o, 0);
    chk(buf_valid_o == m_vld, cause, buf_valid_o, m_vld);
    if (m_vld) begin
      chk(buf_data_o == m_data && buf_addr_o == m_addr, "R5 contents", buf_data_o, m_data);
      chk(buf_rwitm_o == m_rw, "R3 buf intent", buf_rwitm_o, m_rw);
    end
    @(negedge clk_i);
    idle();
  endtask

  function automatic logic [DW-1:0] rdata();
    logic [DW-1:0] d;
    for (int i = 0; i < DW / 32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  task automatic hint(input logic [AW-1:0] a, input bit st);
    hint_valid_i = 1; hint_addr_i = a; hint_store_i = st;
  endtask

  task automatic rsp(input logic [IW-1:0] id);
    rsp_valid_i = 1; rsp_id_i = id; rsp_data_i = rdata();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h7a3c1));
    idle();
    m_pend = 0; m_vld = 0; m_rw = 0; m_addr = '0; m_id = '0; m_data = '0;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk({fetch_req_o, lru_upd_o, hint_nop_o, pte_rc_upd_o, buf_valid_o, fetch_id_o,
         fetch_rwitm_o, buf_rwitm_o} == '0, "R11 reset", buf_valid_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    // R1/R5: load hint then fill
    hint(27'h100, 0); step();
    step();
    rsp(m_id); step();
    // R8 nonmatching zero keeps it, matching clears
    zero_valid_i = 1; zero_addr_i = 27'h101; step();
    zero_valid_i = 1; zero_addr_i = 27'h100; step();
    // R3 store hint, fill, then R6 move
    hint(27'h200, 1); step();
    rsp(m_id); step();
    move_i = 1; step();
    move_i = 1; step();
    // R7 cmo while pending, then response dropped
    hint(27'h300, 0); step();
    cmo_i = 1; step();
    rsp(m_id); step();
    // R10 stale id
    hint(27'h310, 0); step();
    rsp(m_id - 1'b1); step();
    rsp(m_id); step();
    // R9 newer hint replaces; response in same cycle dropped
    hint(27'h320, 1); rsp(m_id); step();
    rsp(m_id); step();
    // R2 each failing condition
    for (int k = 0; k < 7; k++) begin
      hint(27'h400 + k, 0);
      case (k)
        0: xlat_hit_i = 0;
        1: xlat_load_ok_i = 0;
        2: page_guarded_i = 1;
        3: page_wt_i = 1;
        4: page_ci_i = 1;
        5: cache_locked_i = 1;
        default: cache_disabled_i = 1;
      endcase
      step();
    end
    rsp(m_id); step();
    // random mix
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(99) < 20) begin
        hint(27'h500 + $urandom_range(3), $urandom_range(1));
        if ($urandom_range(1)) begin
          xlat_hit_i = $urandom_range(7) != 0; xlat_load_ok_i = $urandom_range(7) != 0;
          page_guarded_i = $urandom_range(7) == 0; page_wt_i = $urandom_range(7) == 0;
          page_ci_i = $urandom_range(7) == 0; cache_locked_i = $urandom_range(7) == 0;
          cache_disabled_i = $urandom_range(7) == 0;
        end
      end
      cmo_i = $urandom_range(99) < 4;
      if ($urandom_range(99) < 10) begin
        zero_valid_i = 1; zero_addr_i = 27'h500 + $urandom_range(3);
      end
      move_i = $urandom_range(99) < 10;
      if ($urandom_range(99) < 35) rsp($urandom_range(3) != 0 ? m_id : IW'($urandom));
      step();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule